// File: doc/BRIEF.md
# Core Performance Counter Unit

This block is a per-core performance monitor with two fixed 48-bit counters. Counter 0 advances on cycles (gated by a cycle-enable input) and counter 1 advances on retired-instruction strobes. Each counter counts only when its enable bit in the control register is set and when the mode filter allows the execution mode the core is currently in.

When a counter steps from 2^47-1 to 2^47, the unit latches an overflow status bit. If that counter's interrupt enable is set, an interrupt is raised on one of four output lines chosen by a route code. Software takes periodic samples by preloading a counter with (2^47-1)-P, which gives an overflow after P+1 events. Two further control bits can stop all counting once an interrupt is delivered, and can hold delivery back until an exception return has retired.

A single-cycle register port gives access to the control, filter and status registers and to both counters. Reads are combinational and writes take effect at the next clock edge.

Top module: `pmu_core`

## Requirements
- R1: After reset every register reads zero and no interrupt line is asserted. Register addresses: 0 control, 1 mode filter, 2 status, 3 counter 0, 4 counter 1; other addresses read zero.
- R2: Counter 0 increments by one on each clock edge where cyc_en_i is high, control bit 0 is set and the filter allows counter 0 in the current mode.
- R3: Counter 1 increments by one on each clock edge where instr_ret_i is high, control bit 1 is set and the filter allows counter 1 in the current mode.
- R4: Mode encoding on mode_i: 0 EL0 AArch32, 1 EL0 AArch64, 2 EL1, 3 EL3. Filter bit 8*mode+n permits counter n in that mode. While that bit is clear, the counter holds its value.
- R5: A register-port write to a counter loads the value at the next edge and overrides an event in the same cycle. A write never sets an overflow status bit.
- R6: An increment from 2^47-1 to 2^47 on counter n sets status bit n at the same edge. A preload of (2^47-1)-P therefore sets the bit after P+1 events.
- R7: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. A hardware set in the same cycle wins over the clear.
- R8: Control bits 10:8 hold the route code: 1, 2, 3 and 4 drive irq_o[0], irq_o[1], irq_o[2] and irq_o[3]. Codes 0 and 5 to 7 drive no line. The selected line is high while (status & control bits 13:12) is nonzero and delivery is not held, and it falls the cycle after the status is cleared.
- R9: Control bit 11 is set at each edge where an interrupt line is high. Writing 1 to it clears it.
- R10: When control bit 20 is set, an edge with an interrupt line high clears control bits 1:0. An event in the delivery cycle is still counted.
- R11: When control bit 22 is set, a pending interrupt stays off until an eret_i pulse. The line rises the cycle after the pulse and stays high while the interrupt is pending. Once the pending condition clears, a new overflow needs a new pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cyc_en_i | input | 1 | Cycle counting qualifier |
| instr_ret_i | input | 1 | One pulse per retired instruction |
| mode_i | input | 2 | Current execution mode |
| eret_i | input | 1 | Exception return retired pulse |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | CNT_W | Write data |
| reg_rdata_o | output | CNT_W | Read data, combinational |
| irq_o | output | 4 | Overflow interrupt lines, one per route code 1 to 4 |

## Verification
The hardest state to reach is the hold-off path. An overflow must already be pending with hold enabled before the exception-return pulse arrives. After the pulse, the release must be shown to lapse once the status is cleared. The bench gets there by preloading a counter to 2^47-1 with one event pending. It waits several cycles with the line low, pulses eret_i, and then clears the status. A second overflow is then forced, and the bench checks that the line stays low without a fresh pulse. The stop-on-delivery case uses a preload of 2^47-2 with counting left running, so the one-cycle slip before the enables drop appears in the final count.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int N_CNT    = 2;
  localparam int N_MODE   = 4;
  localparam int N_ROUTE  = 4;
  localparam int ADDR_W   = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CTL  = 3'd0,
    A_FILT = 3'd1,
    A_STAT = 3'd2,
    A_CNT0 = 3'd3,
    A_CNT1 = 3'd4
  } reg_addr_e;

  typedef enum logic [1:0] {
    M_EL0_32 = 2'd0,
    M_EL0_64 = 2'd1,
    M_EL1    = 2'd2,
    M_EL3    = 2'd3
  } exec_mode_e;

  // control register bit positions
  localparam int C_EN_LO   = 0;
  localparam int C_RT_LO   = 8;
  localparam int C_DLV     = 11;
  localparam int C_IE_LO   = 12;
  localparam int C_STOP    = 20;
  localparam int C_HOLD    = 22;
  localparam int FILT_STRIDE = 8;
endpackage

// File: rtl/pmu_counter.sv
module pmu_counter #(
  parameter int CNT_W = 48
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  localparam logic [CNT_W-1:0] THRESH = {1'b0, {(CNT_W-1){1'b1}}};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (wr_i)   cnt_q <= wdata_i;
    else if (inc_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign ovf_o = inc_i && !wr_i && (cnt_q == THRESH);
  assign cnt_o = cnt_q;
endmodule

// File: rtl/pmu_irq.sv
module pmu_irq #(
  parameter int N_LINE = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pend_i,
  input  logic              hold_en_i,
  input  logic              eret_i,
  input  logic [2:0]        route_i,
  output logic              deliver_o,
  output logic [N_LINE-1:0] irq_o
);
  logic route_ok;
  logic rel_q;

  assign route_ok = (route_i != 3'd0) && (int'(route_i) <= N_LINE);

  // release latch: set by eret while pending, lapses when pending drops
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rel_q <= 1'b0;
    else         rel_q <= pend_i && hold_en_i && route_ok && (rel_q || eret_i);
  end

  assign deliver_o = pend_i && route_ok && (!hold_en_i || rel_q);

  for (genvar k = 0; k < N_LINE; k++) begin : g_line
    assign irq_o[k] = deliver_o && (int'(route_i) == k + 1);
  end
endmodule

// File: rtl/pmu_core.sv
module pmu_core
  import pmu_pkg::*;
#(
  parameter int CNT_W = 48
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cyc_en_i,
  input  logic              instr_ret_i,
  input  logic [1:0]        mode_i,
  input  logic              eret_i,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [CNT_W-1:0]  reg_wdata_i,
  output logic [CNT_W-1:0]  reg_rdata_o,
  output logic [3:0]        irq_o
);
  localparam int FILT_W = FILT_STRIDE * (N_MODE - 1) + N_CNT;

  logic [N_CNT-1:0]               en_q, irqen_q, status_q;
  logic [2:0]                     route_q;
  logic                           dlv_q, stop_q, hold_q;
  logic [N_MODE-1:0][N_CNT-1:0]   filt_q;
  logic [N_CNT-1:0]               inc, ovf, wr_cnt, ev;
  logic [N_CNT-1:0][CNT_W-1:0]    cnt_w;
  logic                           wr_ctl, wr_filt, wr_stat, deliver, pend;

  assign wr_ctl  = reg_we_i && (reg_addr_i == A_CTL);
  assign wr_filt = reg_we_i && (reg_addr_i == A_FILT);
  assign wr_stat = reg_we_i && (reg_addr_i == A_STAT);

  assign ev[0] = cyc_en_i;
  assign ev[1] = instr_ret_i;

  for (genvar n = 0; n < N_CNT; n++) begin : g_cnt
    assign inc[n]    = ev[n] && en_q[n] && filt_q[mode_i][n];
    assign wr_cnt[n] = reg_we_i && (int'(reg_addr_i) == int'(A_CNT0) + n);
    pmu_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .inc_i   (inc[n]),
      .wr_i    (wr_cnt[n]),
      .wdata_i (reg_wdata_i),
      .cnt_o   (cnt_w[n]),
      .ovf_o   (ovf[n])
    );
  end

  assign pend = |(status_q & irqen_q);

  pmu_irq #(.N_LINE(N_ROUTE)) u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pend_i    (pend),
    .hold_en_i (hold_q),
    .eret_i    (eret_i),
    .route_i   (route_q),
    .deliver_o (deliver),
    .irq_o     (irq_o)
  );

  // control register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= '0;
      route_q <= '0;
      irqen_q <= '0;
      stop_q  <= 1'b0;
      hold_q  <= 1'b0;
    end else if (wr_ctl) begin
      en_q    <= reg_wdata_i[C_EN_LO +: N_CNT];
      route_q <= reg_wdata_i[C_RT_LO +: 3];
      irqen_q <= reg_wdata_i[C_IE_LO +: N_CNT];
      stop_q  <= reg_wdata_i[C_STOP];
      hold_q  <= reg_wdata_i[C_HOLD];
    end else if (deliver && stop_q) begin
      en_q    <= '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            dlv_q <= 1'b0;
    else if (deliver)                       dlv_q <= 1'b1;
    else if (wr_ctl && reg_wdata_i[C_DLV])  dlv_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      filt_q <= '0;
    else if (wr_filt) begin
      for (int m = 0; m < N_MODE; m++)
        filt_q[m] <= reg_wdata_i[FILT_STRIDE*m +: N_CNT];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else status_q <= (status_q & ~(wr_stat ? reg_wdata_i[N_CNT-1:0] : {N_CNT{1'b0}})) | ovf;
  end

  // read mux
  logic [CNT_W-1:0] ctl_rd, filt_rd;
  always_comb begin
    ctl_rd = '0;
    ctl_rd[C_EN_LO +: N_CNT] = en_q;
    ctl_rd[C_RT_LO +: 3]     = route_q;
    ctl_rd[C_DLV]            = dlv_q;
    ctl_rd[C_IE_LO +: N_CNT] = irqen_q;
    ctl_rd[C_STOP]           = stop_q;
    ctl_rd[C_HOLD]           = hold_q;
    filt_rd = '0;
    for (int m = 0; m < N_MODE; m++)
      filt_rd[FILT_STRIDE*m +: N_CNT] = filt_q[m];
  end

  always_comb begin
    unique case (reg_addr_i)
      A_CTL:   reg_rdata_o = ctl_rd;
      A_FILT:  reg_rdata_o = filt_rd;
      A_STAT:  reg_rdata_o = {{(CNT_W-N_CNT){1'b0}}, status_q};
      A_CNT0:  reg_rdata_o = cnt_w[0];
      A_CNT1:  reg_rdata_o = cnt_w[1];
      default: reg_rdata_o = '0;
    endcase
  end

  logic unused_filt_w;
  assign unused_filt_w = (FILT_W > CNT_W);
endmodule

// File: rtl/pmu_core_chk.sv
module pmu_core_chk #(
  parameter int CNT_W = 48
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  eret_i,
  input logic [3:0]            irq_o,
  input logic [2:0]            route_q,
  input logic [1:0]            status_q,
  input logic [1:0]            irqen_q,
  input logic [1:0]            en_q,
  input logic                  stop_q,
  input logic                  hold_q,
  input logic                  dlv_q,
  input logic                  wr_ctl,
  input logic [1:0]            ovf,
  input logic [1:0]            inc,
  input logic [1:0]            wr_cnt,
  input logic [1:0][CNT_W-1:0] cnt_w
);
  p_onehot_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(irq_o));

  p_route_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (route_q == 3'd0 || route_q > 3'd4) |-> irq_o == 4'b0);

  p_irq_pending_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|irq_o) |-> (|(status_q & irqen_q)));

  p_ovf_status_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf[0] |=> status_q[0]);

  p_ovf_status1_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf[1] |=> status_q[1]);

  p_dlv_flag_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|irq_o) |=> dlv_q);

  p_stop_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|irq_o) && stop_q && !wr_ctl) |=> en_q == 2'b00);

  p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|irq_o) && hold_q) |-> ($past(eret_i) || $past(|irq_o)));

  p_idle_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc[0] && !wr_cnt[0]) |=> $stable(cnt_w[0]));

  p_idle_hold1_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc[1] && !wr_cnt[1]) |=> $stable(cnt_w[1]));
endmodule

bind pmu_core pmu_core_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .eret_i   (eret_i),
  .irq_o    (irq_o),
  .route_q  (route_q),
  .status_q (status_q),
  .irqen_q  (irqen_q),
  .en_q     (en_q),
  .stop_q   (stop_q),
  .hold_q   (hold_q),
  .dlv_q    (dlv_q),
  .wr_ctl   (wr_ctl),
  .ovf      (ovf),
  .inc      (inc),
  .wr_cnt   (wr_cnt),
  .cnt_w    (cnt_w)
);

// File: tb/sim_pmu_core.sv
module sim_pmu_core;
  localparam int CLK_P = 10;
  localparam int W = 48;
  localparam logic [W-1:0] TH = {1'b0, {(W-1){1'b1}}};

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cyc_en = 0, instr = 0, eret = 0, we = 0;
  logic [1:0] mode = 0;
  logic [2:0] addr = 0;
  logic [W-1:0] wdata = 0, rdata;
  logic [3:0] irq;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  pmu_core #(.CNT_W(W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cyc_en_i(cyc_en), .instr_ret_i(instr),
    .mode_i(mode), .eret_i(eret), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    @(negedge clk);
    we = 1; addr = a; wdata = d;
    @(negedge clk);
    we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [W-1:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic t_reset;
    logic [W-1:0] d;
    for (int a = 0; a < 8; a++) begin
      rd(a[2:0], d);
      chk("R1 reg zero", d, 0);
    end
    chk("R1 irq idle", irq, 0);
  endtask

  task automatic t_cycles;
    logic [W-1:0] d;
    wr(1, 48'h0303_0303);
    wr(0, 48'h1);
    cyc_en = 1; step(10); cyc_en = 0;
    rd(3, d); chk("R2 cycle count", d, 10);
  endtask

  task automatic t_instr;
    logic [W-1:0] d;
    wr(0, 48'h2);
    for (int i = 0; i < 9; i++) begin
      instr = (i % 2 == 0); step(1);
    end
    instr = 0;
    cyc_en = 1; step(3); cyc_en = 0;
    rd(4, d); chk("R3 instr count", d, 5);
    rd(3, d); chk("R2 disabled cycle holds", d, 10);
  endtask

  task automatic t_filter;
    logic [W-1:0] d;
    wr(1, 48'h0002_0001);
    wr(0, 48'h3);
    cyc_en = 1; instr = 1;
    mode = 1; step(4);
    cyc_en = 0; instr = 0;
    rd(3, d); chk("R4 el0_64 blocks c0", d, 10);
    rd(4, d); chk("R4 el0_64 blocks c1", d, 5);
    cyc_en = 1; instr = 1; mode = 2; step(4); cyc_en = 0; instr = 0;
    rd(3, d); chk("R4 el1 blocks c0", d, 10);
    rd(4, d); chk("R4 el1 allows c1", d, 9);
    cyc_en = 1; instr = 1; mode = 0; step(4); cyc_en = 0; instr = 0;
    rd(3, d); chk("R4 el0_32 allows c0", d, 14);
    rd(4, d); chk("R4 el0_32 blocks c1", d, 9);
    cyc_en = 1; instr = 1; mode = 3; step(4); cyc_en = 0; instr = 0;
    rd(3, d); chk("R4 el3 blocks c0", d, 14);
    mode = 0;
  endtask

  task automatic t_write;
    logic [W-1:0] d;
    wr(1, 48'h0303_0303);
    wr(0, 48'h1);
    cyc_en = 1;
    wr(3, 100);
    rd(3, d); chk("R5 write wins", d, 100);
    step(3); cyc_en = 0;
    rd(3, d); chk("R5 count after write", d, 103);
    wr(3, TH + 1);
    rd(2, d); chk("R5 write sets no status", d, 0);
  endtask

  task automatic t_ovf;
    logic [W-1:0] d;
    wr(0, 48'h2);
    wr(4, TH - 3);
    instr = 1; step(3); instr = 0;
    rd(2, d); chk("R6 no status before cross", d, 0);
    rd(4, d); chk("R6 at threshold", d, TH);
    instr = 1; step(1); instr = 0;
    rd(2, d); chk("R6 status on cross", d, 2);
    rd(4, d); chk("R6 value past cross", d, TH + 1);
  endtask

  task automatic t_w1c;
    logic [W-1:0] d;
    wr(2, 1);
    rd(2, d); chk("R7 clear of unset bit", d, 2);
    wr(2, 2);
    rd(2, d); chk("R7 w1c", d, 0);
  endtask

  task automatic t_route;
    logic [W-1:0] d;
    logic [3:0] e;
    wr(0, 48'h2);
    wr(4, TH);
    instr = 1; step(1); instr = 0;
    for (int k = 0; k < 8; k++) begin
      wr(0, (48'h1 << 13) | (48'(k) << 8));
      e = (k >= 1 && k <= 4) ? 4'(1 << (k - 1)) : 4'h0;
      chk("R8 route line", irq, e);
    end
    wr(0, (48'h1 << 13) | (48'd4 << 8));
    step(1);
    rd(0, d); chk("R9 delivered flag", d[11], 1);
    wr(2, 2);
    chk("R8 line drops on clear", irq, 0);
    wr(0, (48'h1 << 11) | (48'h1 << 13) | (48'd4 << 8));
    rd(0, d); chk("R9 flag w1c", d[11], 0);
    wr(0, 0);
  endtask

  task automatic t_stop;
    logic [W-1:0] d;
    wr(0, 48'h1 | (48'h1 << 12) | (48'd4 << 8) | (48'h1 << 20));
    wr(3, TH - 1);
    cyc_en = 1; step(6); cyc_en = 0;
    rd(3, d); chk("R10 count stops", d, TH + 2);
    rd(0, d); chk("R10 enables cleared", d[1:0], 0);
    chk("R10 fiq line", irq, 4'b1000);
    wr(2, 1);
    wr(0, 48'h1 << 11);
  endtask

  task automatic t_hold;
    logic [W-1:0] d;
    wr(0, 48'h1 | (48'h1 << 12) | (48'd1 << 8) | (48'h1 << 22));
    wr(3, TH);
    cyc_en = 1; step(1); cyc_en = 0;
    rd(2, d); chk("R11 status pending", d, 1);
    step(3);
    chk("R11 held off", irq, 0);
    eret = 1; step(1); eret = 0;
    chk("R11 released", irq, 4'b0001);
    step(2);
    chk("R11 stays high", irq, 4'b0001);
    wr(2, 1);
    chk("R11 drops on clear", irq, 0);
    step(1);
    wr(3, TH);
    cyc_en = 1; step(1); cyc_en = 0;
    step(2);
    chk("R11 rearmed hold", irq, 0);
  endtask

  initial begin
    step(2);
    rst_ni = 1;
    step(1);
    t_reset;
    t_cycles;
    t_instr;
    t_filter;
    t_write;
    t_ovf;
    t_w1c;
    t_route;
    t_stop;
    t_hold;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule